// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block records inter-processor software interrupts for a cluster of up to eight CPUs, each with a bank of sixteen interrupt numbers. A CPU raises one by writing a 32-bit command word to the generate port, together with its own CPU number. The command names an interrupt number, a list of destination CPUs and a filter mode. For every CPU that the command selects, the block marks that interrupt pending in the destination's bank and records which CPU asked for it.

Each entry, one per destination CPU and interrupt number, holds an 8-bit mask of requesting CPUs. The entry is pending while that mask is non-zero. Software can also edit the masks directly through two 16-byte windows. The set window ORs bits in and the clear window removes them. Both windows address the accessing CPU's own bank, with byte or aligned-word granularity. A combinational read port returns the masks of a chosen CPU's bank. The pending state of every entry is driven out as a flat vector for a downstream arbiter.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every source mask is zero, every read returns zero and `pend_out` is all zero.
- R2: In a generate command the interrupt number is bits [3:0], the destination list is bits [23:16] and the filter is bits [25:24]. Filter 0 selects the listed CPUs. Destination bits at or above `online_cnt` are discarded under every filter.
- R3: Filter 1 selects every online CPU except the requester.
- R4: Filter 2 selects the requester alone.
- R5: Filter 3 selects no CPU, so the command changes no state.
- R6: For each selected CPU, the command ORs bit `gen_cpu` into that CPU's mask for the interrupt and makes the entry pending. Commands from different requesters accumulate.
- R7: A set-window write ORs data into masks of bank `win_cpu`. A byte access (`win_word`=0) writes data bits [7:0] to interrupt `win_addr`. A word access writes byte k to interrupt 4*`win_addr`[3:2]+k. The entry is pending when the result is non-zero.
- R8: A clear-window write, with the same mapping, removes the written bits from the mask. The entry stays pending while bits remain and stops being pending once the mask is zero.
- R9: The read port returns masks of bank `rd_cpu`. A byte read returns the mask of interrupt `rd_addr` in bits [7:0], with zero above. A word read returns interrupt 4*`rd_addr`[3:2]+k in byte k.
- R10: When a generate command and a window write reach the same entry in one cycle, only the generate command applies to that entry. The other entries of the window write are still updated.
- R11: `pend_out` bit c*16+n is 1 exactly when CPU c's mask for interrupt n is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| online_cnt | input | 4 | Number of online CPUs, 1 to 8 |
| gen_we | input | 1 | Generate command strobe |
| gen_cpu | input | 3 | Requesting CPU of the command |
| gen_wdata | input | 32 | Generate command word |
| win_we | input | 1 | Window write strobe |
| win_set | input | 1 | 1 selects the set window, 0 selects the clear window |
| win_word | input | 1 | 1 for a word access, 0 for a byte access |
| win_cpu | input | 3 | Accessing CPU of the window write |
| win_addr | input | 4 | Byte offset inside the window |
| win_wdata | input | 32 | Window write data |
| rd_cpu | input | 3 | Bank selected for reading |
| rd_word | input | 1 | 1 for a word read, 0 for a byte read |
| rd_addr | input | 4 | Byte offset of the read |
| rd_data | output | 32 | Read data |
| pend_out | output | 128 | Pending flags, bit c*16+n for CPU c and interrupt n |

## Verification
The bench sweeps every requester through all four filters at full and reduced online counts. A wrong exclusion or masking rule would show up as a stray or missing destination. It would also show up if the requester were excluded from a self-only command, or if a reserved command changed state. After every operation, each bank is read back in full at both access sizes. A wrong lane mapping or an unbanked read would therefore return a neighbouring interrupt's or CPU's mask. Partial clears keep the entry pending, and a design that cleared pending on any clear write would drop it. Same-cycle collisions with both windows check that the generate command wins only its own entry and that the other lanes still land.

// File: rtl/sgi_pkg.sv
// Package: shared constants for the software interrupt dispatcher.
// Assumes command field positions are fixed by the software contract.
package sgi_pkg;
    localparam int LANE_W   = 8;   // width of one source mask / window byte
    localparam int SGI_LSB  = 0;   // interrupt number field
    localparam int LIST_LSB = 16;  // destination list field
    localparam int FILT_LSB = 24;  // filter mode field

    typedef enum logic [1:0] {
        FILT_LIST     = 2'd0,
        FILT_OTHERS   = 2'd1,
        FILT_SELF     = 2'd2,
        FILT_RESERVED = 2'd3
    } filt_e;
endpackage

// File: rtl/sgi_target_decode.sv
// Module: decodes a generate command into a destination CPU mask,
// the interrupt number and a one-hot requester mask.
// Assumes NCPU <= 8 and that online_cnt is at least 1.
module sgi_target_decode
    import sgi_pkg::*;
#(
    parameter int NCPU  = 8,
    parameter int SGI_W = 4,
    parameter int CPU_W = 3,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_we,
    input  logic [CPU_W-1:0]  gen_cpu,
    input  logic [31:0]       gen_wdata,
    input  logic [CNT_W-1:0]  online_cnt,
    output logic [NCPU-1:0]   tgt,
    output logic [SGI_W-1:0]  sgi_id,
    output logic [LANE_W-1:0] req_oh
);
    filt_e           filt;
    logic [NCPU-1:0] list;
    logic [NCPU-1:0] online_m;
    logic [NCPU-1:0] self_m;
    logic [NCPU-1:0] raw;
    logic            unused_bits;

    // Split the command word into its fields.
    always_comb begin
        filt   = filt_e'(gen_wdata[FILT_LSB +: 2]);
        list   = gen_wdata[LIST_LSB +: NCPU];
        sgi_id = gen_wdata[SGI_LSB +: SGI_W];
    end

    assign unused_bits = ^{gen_wdata[31:FILT_LSB+2], gen_wdata[LIST_LSB-1:SGI_LSB+SGI_W],
                           gen_wdata[LIST_LSB+LANE_W-1:LIST_LSB+NCPU-1]};

    // Build the online mask and the requester one-hot masks.
    always_comb begin
        req_oh = '0;
        for (int c = 0; c < NCPU; c++) begin
            online_m[c] = (CNT_W'(c) < online_cnt);
            self_m[c]   = (CPU_W'(c) == gen_cpu);
            req_oh[c]   = self_m[c];
        end
    end

    // Apply the filter, then drop CPUs that are not online.
    always_comb begin
        case (filt)
            FILT_LIST:   raw = list;
            FILT_OTHERS: raw = ~self_m;
            FILT_SELF:   raw = self_m;
            default:     raw = '0;
        endcase
        tgt = gen_we ? (raw & online_m) : '0;
    end

    assert_offline_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (({{(32-NCPU){1'b0}}, tgt} >> online_cnt) == 32'd0));
    assert_others_skip_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_we && gen_wdata[FILT_LSB +: 2] == 2'd1) |-> ((tgt & req_oh[NCPU-1:0]) == '0));
    assert_self_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_we && gen_wdata[FILT_LSB +: 2] == 2'd2) |-> $onehot0(tgt));
    assert_reserved_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_we && gen_wdata[FILT_LSB +: 2] == 2'd3) |-> (tgt == '0));
endmodule

// File: rtl/sgi_entry.sv
// Module: one destination/interrupt entry holding a source mask and a
// pending flag. Assumes the caller has already resolved collision
// priority inputs; a generate hit overrides any window write.
module sgi_entry
    import sgi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_hit,
    input  logic [LANE_W-1:0] req_oh,
    input  logic              win_hit,
    input  logic              win_set,
    input  logic [LANE_W-1:0] win_byte,
    output logic [LANE_W-1:0] src,
    output logic              pend
);
    logic [LANE_W-1:0] win_nxt;

    // Next mask for a window write.
    always_comb begin
        win_nxt = win_set ? (src | win_byte) : (src & ~win_byte);
    end

    // Update mask and pending flag; generate command has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src  <= '0;
            pend <= 1'b0;
        end else if (gen_hit) begin
            src  <= src | req_oh;
            pend <= 1'b1;
        end else if (win_hit) begin
            src  <= win_nxt;
            pend <= |win_nxt;
        end
    end

    assert_pend_tracks_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pend == (src != '0));
    assert_gen_records_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gen_hit |=> (pend && ((src & $past(req_oh)) == $past(req_oh))));
    assert_clear_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && !win_set && !gen_hit) |=> ((src & ~$past(src)) == '0));
    assert_gen_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_hit && win_hit && !win_set) |=> ((src & $past(req_oh)) == $past(req_oh)));
endmodule

// File: rtl/sgi_read_mux.sv
// Module: combinational banked read of source masks, byte or aligned word.
// Assumes NSGI is a multiple of four.
module sgi_read_mux
    import sgi_pkg::*;
#(
    parameter int NCPU   = 8,
    parameter int NSGI   = 16,
    parameter int CPU_W  = 3,
    parameter int ADDR_W = 4
) (
    input  logic [NCPU*NSGI-1:0][LANE_W-1:0] src_all,
    input  logic [CPU_W-1:0]                 rd_cpu,
    input  logic                             rd_word,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [31:0]                      rd_data
);
    // Select the bank, then gather one byte or four consecutive bytes.
    always_comb begin
        int bank;
        int base;
        bank    = int'(rd_cpu) * NSGI;
        base    = int'({rd_addr[ADDR_W-1:2], 2'b00});
        rd_data = '0;
        if (rd_word) begin
            for (int k = 0; k < 4; k++)
                rd_data[LANE_W*k +: LANE_W] = src_all[bank + base + k];
        end else begin
            rd_data[LANE_W-1:0] = src_all[bank + int'(rd_addr)];
        end
    end
endmodule

// File: rtl/sgi_dispatch.sv
// Module: top of the software interrupt dispatcher. Decodes generate
// commands and window writes into per-entry strobes, holds NCPU x NSGI
// entries and serves banked reads. Assumes NCPU <= 8, NSGI = 2**ADDR_W.
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NCPU = 8,
    parameter int NSGI = 16,
    localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int CNT_W  = $clog2(NCPU + 1),
    localparam int ADDR_W = $clog2(NSGI)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CNT_W-1:0]       online_cnt,
    input  logic                   gen_we,
    input  logic [CPU_W-1:0]       gen_cpu,
    input  logic [31:0]            gen_wdata,
    input  logic                   win_we,
    input  logic                   win_set,
    input  logic                   win_word,
    input  logic [CPU_W-1:0]       win_cpu,
    input  logic [ADDR_W-1:0]      win_addr,
    input  logic [31:0]            win_wdata,
    input  logic [CPU_W-1:0]       rd_cpu,
    input  logic                   rd_word,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [31:0]            rd_data,
    output logic [NCPU*NSGI-1:0]   pend_out
);
    logic [NCPU-1:0]                  tgt;
    logic [ADDR_W-1:0]                sgi_id;
    logic [LANE_W-1:0]                req_oh;
    logic [NCPU*NSGI-1:0][LANE_W-1:0] src_all;

    sgi_target_decode #(
        .NCPU(NCPU), .SGI_W(ADDR_W), .CPU_W(CPU_W), .CNT_W(CNT_W)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .gen_we(gen_we), .gen_cpu(gen_cpu),
        .gen_wdata(gen_wdata), .online_cnt(online_cnt),
        .tgt(tgt), .sgi_id(sgi_id), .req_oh(req_oh)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        for (genvar s = 0; s < NSGI; s++) begin : g_sgi
            localparam int IDX  = c * NSGI + s;
            localparam int LANE = s % 4;
            logic              hit_g;
            logic              hit_w;
            logic [LANE_W-1:0] wbyte;

            // Per-entry strobes from the command and window decoders.
            always_comb begin
                hit_g = tgt[c] && (sgi_id == ADDR_W'(s));
                if (win_word) begin
                    hit_w = win_we && (win_cpu == CPU_W'(c)) &&
                            (win_addr[ADDR_W-1:2] == ADDR_W'(s) >> 2);
                    wbyte = win_wdata[LANE_W*LANE +: LANE_W];
                end else begin
                    hit_w = win_we && (win_cpu == CPU_W'(c)) && (win_addr == ADDR_W'(s));
                    wbyte = win_wdata[LANE_W-1:0];
                end
            end

            sgi_entry u_ent (
                .clk(clk), .rst_n(rst_n), .gen_hit(hit_g), .req_oh(req_oh),
                .win_hit(hit_w), .win_set(win_set), .win_byte(wbyte),
                .src(src_all[IDX]), .pend(pend_out[IDX])
            );
        end
    end

    sgi_read_mux #(
        .NCPU(NCPU), .NSGI(NSGI), .CPU_W(CPU_W), .ADDR_W(ADDR_W)
    ) u_rd (
        .src_all(src_all), .rd_cpu(rd_cpu), .rd_word(rd_word),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: tb/sim_sgi_dispatch.sv
// Bench: sweeps generate filters, window accesses and collisions against
// an arithmetic reference model; full bank readback after every operation.
module sim_sgi_dispatch;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   online_cnt = 4'd8;
    logic         gen_we = 1'b0;
    logic [2:0]   gen_cpu = '0;
    logic [31:0]  gen_wdata = '0;
    logic         win_we = 1'b0;
    logic         win_set = 1'b0;
    logic         win_word = 1'b0;
    logic [2:0]   win_cpu = '0;
    logic [3:0]   win_addr = '0;
    logic [31:0]  win_wdata = '0;
    logic [2:0]   rd_cpu = '0;
    logic         rd_word = 1'b0;
    logic [3:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic [127:0] pend_out;

    int errors = 0;
    int checks = 0;
    logic [7:0] ref_src [8][16];

    always #5 clk = ~clk;

    sgi_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .online_cnt(online_cnt), .gen_we(gen_we),
        .gen_cpu(gen_cpu), .gen_wdata(gen_wdata), .win_we(win_we),
        .win_set(win_set), .win_word(win_word), .win_cpu(win_cpu),
        .win_addr(win_addr), .win_wdata(win_wdata), .rd_cpu(rd_cpu),
        .rd_word(rd_word), .rd_addr(rd_addr), .rd_data(rd_data),
        .pend_out(pend_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference: destinations of a command per R2..R5.
    function automatic logic [7:0] ref_targets(input logic [2:0] req, input logic [31:0] v);
        logic [7:0] onl;
        logic [7:0] t;
        onl = 8'((16'd1 << online_cnt) - 16'd1);
        case (v[25:24])
            2'd0: t = v[23:16];
            2'd1: t = ~(8'd1 << req);
            2'd2: t = 8'd1 << req;
            default: t = 8'd0;
        endcase
        return t & onl;
    endfunction

    task automatic ref_gen(input logic [2:0] req, input logic [31:0] v);
        logic [7:0] t;
        t = ref_targets(req, v);
        for (int c = 0; c < 8; c++)
            if (t[c]) ref_src[c][v[3:0]] |= (8'd1 << req);
    endtask

    task automatic ref_win(input logic [2:0] cpu, input bit set, input bit word,
                           input logic [3:0] addr, input logic [31:0] d,
                           input logic [7:0] gtgt, input logic [3:0] gsgi);
        int n;
        n = word ? 4 : 1;
        for (int k = 0; k < n; k++) begin
            int s;
            logic [7:0] b;
            s = word ? int'({addr[3:2], 2'b00}) + k : int'(addr);
            b = d[8*k +: 8];
            if (!(gtgt[cpu] && gsgi == 4'(s))) begin
                if (set) ref_src[cpu][s] |= b;
                else     ref_src[cpu][s] &= ~b;
            end
        end
    endtask

    task automatic apply(input bit g, input logic [2:0] req, input logic [31:0] v,
                         input bit w, input logic [2:0] cpu, input bit set,
                         input bit word, input logic [3:0] addr, input logic [31:0] d);
        @(negedge clk);
        gen_we = g; gen_cpu = req; gen_wdata = v;
        win_we = w; win_cpu = cpu; win_set = set; win_word = word;
        win_addr = addr; win_wdata = d;
        @(negedge clk);
        gen_we = 1'b0; win_we = 1'b0;
        if (g) begin
            logic [7:0] t;
            t = ref_targets(req, v);
            if (w) ref_win(cpu, set, word, addr, d, t, v[3:0]);
            ref_gen(req, v);
        end else if (w) begin
            ref_win(cpu, set, word, addr, d, 8'd0, 4'd0);
        end
    endtask

    // Full readback of every bank at both sizes, plus the pending vector.
    task automatic compare(input string tag);
        logic [127:0] ep;
        for (int c = 0; c < 8; c++) begin
            for (int wd = 0; wd < 4; wd++) begin
                logic [31:0] e;
                rd_cpu = 3'(c); rd_word = 1'b1; rd_addr = 4'(wd * 4 + 1);
                #1;
                e = {ref_src[c][wd*4+3], ref_src[c][wd*4+2], ref_src[c][wd*4+1], ref_src[c][wd*4]};
                chk(rd_data == e, {tag, " R9 word read"}, 128'(rd_data), 128'(e));
            end
            for (int s = 0; s < 16; s++) begin
                rd_cpu = 3'(c); rd_word = 1'b0; rd_addr = 4'(s);
                #1;
                chk(rd_data == {24'd0, ref_src[c][s]}, {tag, " R9 byte read"},
                    128'(rd_data), 128'(ref_src[c][s]));
                ep[c*16+s] = (ref_src[c][s] != 8'd0);
            end
        end
        chk(pend_out == ep, {tag, " R11 pending vector"}, pend_out, ep);
    endtask

    task automatic clear_all();
        for (int c = 0; c < 8; c++)
            for (int wd = 0; wd < 4; wd++)
                apply(1'b0, 3'd0, 32'd0, 1'b1, 3'(c), 1'b0, 1'b1, 4'(wd * 4), 32'hFFFF_FFFF);
    endtask

    initial begin
        for (int c = 0; c < 8; c++)
            for (int s = 0; s < 16; s++) ref_src[c][s] = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");

        // Filters 0..3 from every requester, full and partial online counts.
        for (int oc = 8; oc >= 3; oc -= 5) begin
            online_cnt = 4'(oc);
            for (int f = 0; f < 4; f++) begin
                for (int r = 0; r < 8; r++) begin
                    logic [31:0] v;
                    v = {6'd0, 2'(f), 8'hA5 ^ 8'(r << f), 12'd0, 4'((r * 5 + f) % 16)};
                    apply(1'b1, 3'(r), v, 1'b0, 3'd0, 1'b0, 1'b0, 4'd0, 32'd0);
                    case (f)
                        0: compare("R2 listed targets");
                        1: compare("R3 all but self");
                        2: compare("R4 self only");
                        default: compare("R5 reserved filter");
                    endcase
                end
                clear_all();
                compare("R8 clear all");
            end
        end
        online_cnt = 4'd8;

        // Accumulation from every requester into one entry.
        for (int r = 0; r < 8; r++)
            apply(1'b1, 3'(r), 32'h0008_0009, 1'b0, 3'd0, 1'b0, 1'b0, 4'd0, 32'd0);
        compare("R6 accumulate");

        // Set window, byte then word, in every bank.
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < 16; s++)
                apply(1'b0, 3'd0, 32'd0, 1'b1, 3'(c), 1'b1, 1'b0, 4'(s),
                      {24'hFFFFFF, 8'((c * 16 + s) & 8'h0F)});
            apply(1'b0, 3'd0, 32'd0, 1'b1, 3'(c), 1'b1, 1'b1, 4'(4 + c % 3),
                  32'h8040_2010 >> c);
        end
        compare("R7 set window");

        // Partial then full clears.
        for (int c = 0; c < 8; c++)
            apply(1'b0, 3'd0, 32'd0, 1'b1, 3'(c), 1'b0, 1'b1, 4'd4, 32'h0101_0101);
        compare("R8 partial clear");
        for (int c = 0; c < 8; c++)
            apply(1'b0, 3'd0, 32'd0, 1'b1, 3'(c), 1'b0, 1'b0, 4'(c), 32'h0000_00FF);
        compare("R8 byte clear");

        // Collisions: generate wins its entry, other lanes still apply.
        apply(1'b1, 3'd1, 32'h0004_0005, 1'b1, 3'd2, 1'b0, 1'b1, 4'd4, 32'hFFFF_FFFF);
        compare("R10 collision clear");
        apply(1'b1, 3'd6, 32'h0200_000C, 1'b1, 3'd6, 1'b1, 1'b1, 4'd12, 32'h1122_3344);
        compare("R10 collision set");
        apply(1'b1, 3'd0, 32'h0300_0003, 1'b1, 3'd0, 1'b0, 1'b0, 4'd3, 32'h0000_00FF);
        compare("R5 reserved with clear");

        clear_all();
        compare("R8 final clear");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule